// File: doc/BRIEF.md
# Modulo Counter with Terminal-Value Reload

This block is a synchronous binary counter with a parallel load path, a count enable and a carry output. A small control stage watches the registered count. When it reaches a terminal value chosen by parameter, the control stage turns the next count step into a load of a parameter-chosen reload value. The counter then runs through a short repeating sequence whose length and starting point are both set by parameters, instead of wrapping at all-ones.

An outside load request always takes the data input, whether or not counting is enabled. With the enable low, the count holds, and that includes holding at the terminal value. A synchronous reset returns the count to a parameter-chosen preset. The carry output is combinational, so a further counter can use it as its enable when counters are chained.

Two settings matter most. The first uses terminal 6, reload 0 and preset 0, and gives the seven states 0 to 6. The second uses terminal 14, reload 9 and preset 9, and gives the six states 9 to 14.

Top module: `modcnt_reload`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes the preset value `RESET_VAL`, whatever `load_i` and `cnt_en_i` are.
- R2: With `load_i`=0 and `cnt_en_i`=0, the count keeps its value on the clock edge.
- R3: With `load_i`=0 and `cnt_en_i`=1, and the count not equal to `TERM_VAL`, the count increases by one on the edge, and all-ones (15 for W=4) goes to 0.
- R4: With `load_i`=1, the count takes `data_i` on the edge, for either value of `cnt_en_i`.
- R5: With `load_i`=0 and `cnt_en_i`=1, a count equal to `TERM_VAL` is replaced by `RELOAD_VAL` on that edge.
- R6: With terminal 6, reload 0 and preset 0, the enabled count runs 0,1,2,3,4,5,6,0,1,...
- R7: With terminal 14, reload 9 and preset 9, reset gives 9, and the enabled count runs 9,10,11,12,13,14,9,...
- R8: `carry_o` is 1 exactly when `cnt_en_i`=1 and the count is all-ones (15). It follows these inputs in the same cycle, with no clock edge between.
- R9: With `load_i`=1 while the count equals `TERM_VAL` and `cnt_en_i`=1, `data_i` is loaded and `RELOAD_VAL` is not.
- R10: With `cnt_en_i`=0, a count equal to `TERM_VAL` is held and not reloaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset to `RESET_VAL` |
| load_i | input | 1 | Parallel load request; takes priority over counting |
| cnt_en_i | input | 1 | Count enable |
| data_i | input | W | Parallel load value |
| count_o | output | W | Registered count |
| carry_o | output | 1 | Combinational carry: enable AND count all-ones |

## Verification
The bench builds two copies at W=4. One uses terminal 6, reload 0 and preset 0. The other uses terminal 14, reload 9 and preset 9. The first copy reaches the reload-to-zero wrap, hold at the terminal value, and the natural 15-to-0 wrap with carry, which it gets to by loading a value above the terminal. The second copy shows a sequence that begins at a non-zero preset. It also shows reset taking priority over an active count partway through the run.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/modcnt_ctrl.sv
module modcnt_ctrl
  import modcnt_pkg::*;
#(
  parameter int W        = 4,
  parameter int TERM_VAL = 6,
  parameter int RELOAD_VAL = 0
) (
  input  logic         load_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] q_i,
  output cnt_op_e      op_o,
  output logic [W-1:0] ld_data_o
);
  localparam logic [W-1:0] TermV   = W'(TERM_VAL);
  localparam logic [W-1:0] ReloadV = W'(RELOAD_VAL);

  logic term_hit;
  assign term_hit = (q_i == TermV);

  // Outside load wins, then terminal reload, then plain increment.
  always_comb begin
    op_o      = OP_HOLD;
    ld_data_o = data_i;
    if (load_i) begin
      op_o      = OP_LOAD;
      ld_data_o = data_i;
    end else if (cnt_en_i && term_hit) begin
      op_o      = OP_LOAD;
      ld_data_o = ReloadV;
    end else if (cnt_en_i) begin
      op_o      = OP_INC;
    end
  end
endmodule

// File: rtl/modcnt_reg.sv
module modcnt_reg
  import modcnt_pkg::*;
#(
  parameter int W         = 4,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_op_e      op_i,
  input  logic [W-1:0] ld_data_i,
  input  logic         cnt_en_i,
  output logic [W-1:0] q_o,
  output logic         co_o
);
  localparam logic [W-1:0] PresetV = W'(RESET_VAL);
  localparam logic [W-1:0] AllOnes = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= PresetV;
    end else begin
      unique case (op_i)
        OP_LOAD: q_o <= ld_data_i;
        OP_INC:  q_o <= q_o + W'(1);
        default: q_o <= q_o;
      endcase
    end
  end

  assign co_o = cnt_en_i && (q_o == AllOnes);

  // R1: reset preset after any edge with rst high
  a_r1_reset_preset: assert property (@(posedge clk)
    rst |=> (q_o == PresetV));
endmodule

// File: rtl/modcnt_reload.sv
module modcnt_reload
  import modcnt_pkg::*;
#(
  parameter int W          = 4,
  parameter int TERM_VAL   = 6,
  parameter int RELOAD_VAL = 0,
  parameter int RESET_VAL  = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_o
);
  localparam logic [W-1:0] TermV   = W'(TERM_VAL);
  localparam logic [W-1:0] ReloadV = W'(RELOAD_VAL);
  localparam logic [W-1:0] AllOnes = {W{1'b1}};
  localparam logic [W-1:0] AfterMax = (TermV == AllOnes) ? ReloadV : '0;

  cnt_op_e      op;
  logic [W-1:0] ld_data;

  modcnt_ctrl #(.W(W), .TERM_VAL(TERM_VAL), .RELOAD_VAL(RELOAD_VAL)) ctrl_i (
    .load_i    (load_i),
    .cnt_en_i  (cnt_en_i),
    .data_i    (data_i),
    .q_i       (count_o),
    .op_o      (op),
    .ld_data_o (ld_data)
  );

  modcnt_reg #(.W(W), .RESET_VAL(RESET_VAL)) reg_i (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .ld_data_i (ld_data),
    .cnt_en_i  (cnt_en_i),
    .q_o       (count_o),
    .co_o      (carry_o)
  );

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !cnt_en_i) |=> $stable(count_o));

  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_en_i && count_o != TermV) |=> (count_o == W'($past(count_o) + W'(1))));

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (count_o == $past(data_i)));

  a_r5_term_reload: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_en_i && count_o == TermV) |=> (count_o == ReloadV));

  a_r8_carry_wrap: assert property (@(posedge clk) disable iff (rst)
    (carry_o && !load_i) |=> (count_o == AfterMax));

  a_r10_term_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !cnt_en_i && count_o == TermV) |=> (count_o == TermV));
endmodule

// File: tb/modcnt_reload_tb_top.sv
`timescale 1ns/1ps
module modcnt_reload_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       a_load = 1'b0, a_en = 1'b0;
  logic [3:0] a_data = '0;
  logic [3:0] a_cnt;
  logic       a_co;
  logic       b_load = 1'b0, b_en = 1'b0;
  logic [3:0] b_data = '0;
  logic [3:0] b_cnt;
  logic       b_co;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  modcnt_reload #(.W(4), .TERM_VAL(6), .RELOAD_VAL(0), .RESET_VAL(0)) dut_i (
    .clk(clk), .rst(rst), .load_i(a_load), .cnt_en_i(a_en), .data_i(a_data),
    .count_o(a_cnt), .carry_o(a_co));

  modcnt_reload #(.W(4), .TERM_VAL(14), .RELOAD_VAL(9), .RESET_VAL(9)) dut_b_i (
    .clk(clk), .rst(rst), .load_i(b_load), .cnt_en_i(b_en), .data_i(b_data),
    .count_o(b_cnt), .carry_o(b_co));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int nxt(int prev, int term, int rel);
    if (prev == term) return rel;
    return (prev + 1) % 16;
  endfunction

  task automatic t_reset();
    rst = 1'b1; a_load = 1'b1; a_data = 4'd5; a_en = 1'b1;
    b_load = 1'b1; b_data = 4'd2; b_en = 1'b1;
    step();
    chk("R1 reset A", a_cnt, 0);
    chk("R1 reset B", b_cnt, 9);
    a_load = 1'b0; a_en = 1'b0; b_load = 1'b0; b_en = 1'b0;
    step();
    rst = 1'b0;
    chk("R1 reset hold A", a_cnt, 0);
  endtask

  task automatic t_mod7_seq();
    int exp = 0;
    a_en = 1'b1;
    for (int i = 0; i < 15; i++) begin
      exp = nxt(exp, 6, 0);
      step();
      chk("R6 R5 mod7 sequence", a_cnt, exp);
    end
    a_en = 1'b0;
  endtask

  task automatic t_hold();
    // count is 1 after 15 steps from 0 in mod 7
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R2 hold", a_cnt, 1);
    end
    a_load = 1'b1; a_data = 4'd6; step(); a_load = 1'b0;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R10 hold at terminal", a_cnt, 6);
    end
  endtask

  task automatic t_load();
    a_load = 1'b1; a_data = 4'd11; a_en = 1'b0; step();
    chk("R4 load en=0", a_cnt, 11);
    a_data = 4'd2; a_en = 1'b1; step();
    chk("R4 load en=1", a_cnt, 2);
    a_load = 1'b0; a_en = 1'b0;
  endtask

  task automatic t_wrap_carry();
    a_load = 1'b1; a_data = 4'd13; step(); a_load = 1'b0;
    a_en = 1'b1; #1;
    chk("R8 carry low at 13", a_co, 0);
    step(); chk("R3 inc 14", a_cnt, 14);
    step(); chk("R3 inc 15", a_cnt, 15);
    chk("R8 carry high at 15", a_co, 1);
    a_en = 1'b0; #1;
    chk("R8 carry follows enable", a_co, 0);
    step(); chk("R2 hold at 15", a_cnt, 15);
    a_en = 1'b1; #1;
    chk("R8 carry back high", a_co, 1);
    step(); chk("R3 wrap to 0", a_cnt, 0);
    chk("R8 carry low after wrap", a_co, 0);
    a_en = 1'b0;
  endtask

  task automatic t_load_over_term();
    a_load = 1'b1; a_data = 4'd6; step();
    a_data = 4'd4; a_en = 1'b1; step();
    chk("R9 load beats reload", a_cnt, 4);
    a_load = 1'b0; step();
    chk("R3 after load", a_cnt, 5);
    a_en = 1'b0;
  endtask

  task automatic t_mod6_seq();
    int exp = 9;
    chk("R7 preset", b_cnt, 9);
    b_en = 1'b1;
    for (int i = 0; i < 13; i++) begin
      exp = nxt(exp, 14, 9);
      step();
      chk("R7 R5 mod6 sequence", b_cnt, exp);
    end
    // exp is now 10; run to 12 then reset while counting
    step(); step();
    chk("R7 at 12", b_cnt, 12);
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 reset beats count", b_cnt, 9);
    step();
    chk("R7 resumes", b_cnt, 10);
    b_en = 1'b0;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_mod7_seq();
    t_hold();
    t_load();
    t_wrap_carry();
    t_load_over_term();
    t_mod6_seq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule